// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim and Complete

This block gathers interrupt requests from a configurable set of sources, ranks them by a software-set priority, and presents one interrupt line per target context. Source identifiers start at 1; identifier 0 is reserved and means "nothing to serve". Software sets three things through a simple register bus: a priority for every source, an enable mask for each context, and a threshold for each context. Each source can be set to a level-high or a rising-edge trigger mode.

A context takes an interrupt by reading its claim register. That read returns the best eligible source for the context and, in the same access, removes the source from the pending set. The source then stays in flight and forwards no new request until software writes the same identifier back to the claim register. On that write the source's request gate opens again. The bus is single-cycle. A strobe-qualified read returns its data on the following cycle, and a write takes effect at the clock edge on which it is presented.

Top module: `intc_top`

## Requirements
- R1: Each source s (1..NSRC) has a priority register at byte address 4*s. Only the low PRIO_W bits are stored, and they read back zero-extended. Address 0 (source 0) always reads 0, and writes to it are ignored.
- R2: Context c has an enable mask at byte address 0x2000 + c*0x80. Source s is bit s%32 of the word at offset (s/32)*4. Bit 0 (source 0) always reads 0. The masks of different contexts are independent.
- R3: Context c has a control page at 0x200000 + c*0x1000. Its threshold sits at offset 0x0 and stores PRIO_W bits. Its claim/complete register sits at offset 0x4.
- R4: A source is eligible for a context only when three conditions hold: it is pending, it is enabled for that context, and its priority is strictly greater than the context's threshold. A priority of 0 therefore never interrupts, and a threshold of all ones (7 when PRIO_W=3) masks every source.
- R5: A claim read returns the eligible source with the highest priority. Equal priorities go to the lowest identifier. The read returns 0 when no source is eligible.
- R6: A claim read clears the returned source's pending bit and puts it in flight. While a source is in flight, no new request from it is accepted. Only a write of its identifier to the claim register of a context that has it enabled ends the flight. A write with any other identifier, or to a context without the source enabled, has no effect.
- R7: In level mode, a high line sets pending whenever the source is neither pending nor in flight. After completion, a line that is still high pends the source again.
- R8: In edge mode, only a low-to-high transition of the line sets pending. Transitions seen while the source is pending or in flight are dropped. After completion, a new rising edge is needed.
- R9: Trigger modes are stored at 0x1100 + (s/32)*4, bit s%32, where 1 selects edge and 0 selects level (the reset value). Pending bits read at 0x1000 + (s/32)*4, bit s%32, and also drive the pending_o port.
- R10: irq_o[c] is a register that rises one clock after a source becomes eligible for context c. It falls one clock after no eligible source remains.
- R11: Read data appears on the cycle after the read strobe. It is 0 for unmapped addresses and on cycles with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_irq_i | input | NSRC | Source request lines; bit s is source s (1..NSRC) |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | NCTX | Per-context interrupt request, registered |
| pending_o | output | NSRC | Pending bit of each source 1..NSRC |

## Verification
On every cycle, the assertions check these properties:
- A source is never pending and in flight at the same time.
- A source never re-pends during the cycle its flight is still open.
- Any non-zero claim result refers to a source that is now in flight and not pending.
- An all-ones threshold keeps the context's line low, and the line can only rise after some source was pending.
- Read data is zero on cycles without a read.

The arbitration order, including ties and threshold cut-offs, can only be shown by the bench's scenarios. The same holds for the address map, for mismatched and disabled completions being ignored, and for the difference between level re-sampling and edge re-arming after completion. The bench drains several request patterns and compares every claim result against a priority model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Byte-address map of the register space
  localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
  localparam logic [31:0] MODE_BASE  = 32'h0000_1100;
  localparam logic [31:0] WORD_SPAN  = 32'h0000_0080;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  // Word index inside a context control page
  localparam logic [9:0]  REG_THR    = 10'd0;
  localparam logic [9:0]  REG_CLAIM  = 10'd1;
endpackage

// File: rtl/intc_gateway.sv
module intc_gateway (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic edge_mode_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pending_o,
  output logic inflight_o
);
  logic line_q;
  logic armed;
  logic req;

  assign armed = !pending_o && !inflight_o;
  assign req   = edge_mode_i ? (line_i && !line_q) : line_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q     <= 1'b0;
      pending_o  <= 1'b0;
      inflight_o <= 1'b0;
    end else begin
      line_q <= line_i;
      if (claim_i && pending_o) begin
        pending_o  <= 1'b0;
        inflight_o <= 1'b1;
      end else if (armed && req) begin
        pending_o <= 1'b1;
      end
      if (complete_i && inflight_o) inflight_o <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int NSRC   = 31,
  parameter int PRIO_W = 3,
  parameter int IDW    = 5
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSRC:0]               cand_i,
  input  logic [NSRC:0][PRIO_W-1:0]   prio_i,
  input  logic [PRIO_W-1:0]           thr_i,
  output logic [IDW-1:0]              win_id_o,
  output logic                        irq_o
);
  logic [PRIO_W-1:0] best_p;

  // Ascending scan with strict compare: equal priority keeps the lower ID
  always_comb begin
    best_p   = '0;
    win_id_o = '0;
    for (int s = 0; s <= NSRC; s++) begin
      if (cand_i[s] && (prio_i[s] > thr_i) && (prio_i[s] > best_p)) begin
        best_p   = prio_i[s];
        win_id_o = IDW'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (win_id_o != '0);
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC:1]     src_irq_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NCTX-1:0]   irq_o,
  output logic [NSRC:1]     pending_o
);
  localparam int IDW    = $clog2(NSRC + 1);
  localparam int EN_SH  = $clog2(EN_STRIDE);
  localparam int CTX_SH = $clog2(CTX_STRIDE);

  logic [NSRC:0][PRIO_W-1:0]          prio_q;
  logic [NCTX-1:0][NSRC:0]            en_q;
  logic [NCTX-1:0][PRIO_W-1:0]        thr_q;
  logic [NSRC:1]                      mode_q;
  logic [NSRC:0]                      pend, infl;
  logic [NSRC:1]                      claim_src, done_src;
  logic [NCTX-1:0][IDW-1:0]           win_id;
  logic [31:0]                        rd_val;

  // Address decode
  logic [ADDR_W-1:0] en_off, ctx_off, en_ctx, ctx_sel;
  logic [4:0]        word_sel;
  logic [9:0]        reg_sel;
  logic              is_prio, is_pend, is_mode, is_en, is_ctx;

  assign en_off   = addr_i - ADDR_W'(EN_BASE);
  assign ctx_off  = addr_i - ADDR_W'(CTX_BASE);
  assign en_ctx   = en_off >> EN_SH;
  assign ctx_sel  = ctx_off >> CTX_SH;
  assign word_sel = addr_i[6:2];
  assign reg_sel  = addr_i[11:2];
  assign is_prio  = addr_i < ADDR_W'(PEND_BASE);
  assign is_pend  = (addr_i >= ADDR_W'(PEND_BASE)) && (addr_i < ADDR_W'(PEND_BASE + WORD_SPAN));
  assign is_mode  = (addr_i >= ADDR_W'(MODE_BASE)) && (addr_i < ADDR_W'(MODE_BASE + WORD_SPAN));
  assign is_en    = (addr_i >= ADDR_W'(EN_BASE)) && (en_off < ADDR_W'(NCTX * EN_STRIDE));
  assign is_ctx   = (addr_i >= ADDR_W'(CTX_BASE)) && (ctx_off < ADDR_W'(NCTX * CTX_STRIDE));

  // One request gate per source
  assign pend[0] = 1'b0;
  assign infl[0] = 1'b0;
  generate
    for (genvar s = 1; s <= NSRC; s++) begin : g_gate
      intc_gateway u_gate (
        .clk        (clk),
        .rst        (rst),
        .line_i     (src_irq_i[s]),
        .edge_mode_i(mode_q[s]),
        .claim_i    (claim_src[s]),
        .complete_i (done_src[s]),
        .pending_o  (pend[s]),
        .inflight_o (infl[s])
      );
    end
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      intc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .cand_i  (pend & en_q[c]),
        .prio_i  (prio_q),
        .thr_i   (thr_q[c]),
        .win_id_o(win_id[c]),
        .irq_o   (irq_o[c])
      );
    end
  endgenerate

  assign pending_o = pend[NSRC:1];

  // Claim reads and completion writes
  always_comb begin
    claim_src = '0;
    done_src  = '0;
    for (int c = 0; c < NCTX; c++) begin
      for (int s = 1; s <= NSRC; s++) begin
        if (rd_en_i && is_ctx && ctx_sel == ADDR_W'(c) && reg_sel == REG_CLAIM &&
            win_id[c] == IDW'(s))
          claim_src[s] = 1'b1;
        if (wr_en_i && is_ctx && ctx_sel == ADDR_W'(c) && reg_sel == REG_CLAIM &&
            wdata_i == 32'(s) && en_q[c][s])
          done_src[s] = 1'b1;
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rd_val = '0;
    if (is_prio) begin
      for (int s = 0; s <= NSRC; s++)
        if (reg_sel == 10'(s)) rd_val = 32'(prio_q[s]);
    end else if (is_pend) begin
      for (int s = 1; s <= NSRC; s++)
        if (word_sel == 5'(s / 32)) rd_val[s % 32] = pend[s];
    end else if (is_mode) begin
      for (int s = 1; s <= NSRC; s++)
        if (word_sel == 5'(s / 32)) rd_val[s % 32] = mode_q[s];
    end else if (is_en) begin
      for (int c = 0; c < NCTX; c++)
        for (int s = 1; s <= NSRC; s++)
          if (en_ctx == ADDR_W'(c) && word_sel == 5'(s / 32)) rd_val[s % 32] = en_q[c][s];
    end else if (is_ctx) begin
      for (int c = 0; c < NCTX; c++) begin
        if (ctx_sel == ADDR_W'(c)) begin
          if (reg_sel == REG_THR)        rd_val = 32'(thr_q[c]);
          else if (reg_sel == REG_CLAIM) rd_val = 32'(win_id[c]);
        end
      end
    end
  end

  // Configuration registers and registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      mode_q  <= '0;
      rdata_o <= '0;
    end else begin
      rdata_o <= rd_en_i ? rd_val : 32'd0;
      if (wr_en_i) begin
        for (int s = 1; s <= NSRC; s++) begin
          if (is_prio && reg_sel == 10'(s)) prio_q[s] <= wdata_i[PRIO_W-1:0];
          if (is_mode && word_sel == 5'(s / 32)) mode_q[s] <= wdata_i[s % 32];
          for (int c = 0; c < NCTX; c++)
            if (is_en && en_ctx == ADDR_W'(c) && word_sel == 5'(s / 32))
              en_q[c][s] <= wdata_i[s % 32];
        end
        for (int c = 0; c < NCTX; c++)
          if (is_ctx && ctx_sel == ADDR_W'(c) && reg_sel == REG_THR)
            thr_q[c] <= wdata_i[PRIO_W-1:0];
      end
    end
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 24
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        rd_en_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [31:0]                 rdata_o,
  input logic [NCTX-1:0]             irq_o,
  input logic [NSRC:0]               pend,
  input logic [NSRC:0]               infl,
  input logic [NCTX-1:0][PRIO_W-1:0] thr_q
);
  localparam int IDW = $clog2(NSRC + 1);

  logic claim_rd;
  assign claim_rd = rd_en_i && (addr_i >= ADDR_W'(CTX_BASE)) &&
                    (addr_i < ADDR_W'(CTX_BASE + NCTX * CTX_STRIDE)) &&
                    (addr_i[11:0] == 12'h004);

  AST_CLAIM_TAKES_SOURCE: assert property (@(posedge clk) disable iff (rst)
    claim_rd |=> (rdata_o == 32'd0) ||
                 (rdata_o <= 32'(NSRC) && infl[rdata_o[IDW-1:0]] && !pend[rdata_o[IDW-1:0]])); // R6

  AST_PEND_FLIGHT_EXCL: assert property (@(posedge clk) disable iff (rst)
    (pend & infl) == '0); // R6

  AST_NO_REPEND_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    (pend & ~$past(pend) & $past(infl)) == '0); // R6

  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> rdata_o == 32'd0); // R11

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx_chk
      AST_MAX_THR_MASKS: assert property (@(posedge clk) disable iff (rst)
        (thr_q[c] == '1) |=> !irq_o[c]); // R4
      AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o[c]) |-> $past(|pend)); // R10
    end
  endgenerate
endmodule

bind intc_top intc_checker #(
  .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .pend   (pend),
  .infl   (infl),
  .thr_q  (thr_q)
);

// File: tb/tb_intc_top.sv
`timescale 1ns/1ps
module tb_intc_top;
  localparam int NSRC = 31, NCTX = 2, PRIO_W = 3, ADDR_W = 24;
  localparam logic [31:0] CLAIM0 = 32'h0020_0004, CLAIM1 = 32'h0020_1004;
  localparam logic [31:0] THR0 = 32'h0020_0000, THR1 = 32'h0020_1000;

  logic clk = 1'b0, rst = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NSRC:1] src = '0;
  logic [NSRC:1] pending;
  logic [NCTX-1:0] irq;

  int checks = 0, fails = 0;
  bit done = 0;
  int prio_m [0:31];
  logic [31:0] pend_m = '0;

  always #4 clk = ~clk;

  intc_top #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .src_irq_i(src), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pending_o(pending)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a[ADDR_W-1:0]; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a[ADDR_W-1:0];
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int s);
    @(negedge clk); src[s] = 1'b1;
    @(negedge clk); src[s] = 1'b0;
  endtask

  // Model: context 0 has every source enabled
  function automatic int best(logic [31:0] pm, int thr);
    int bp = 0, id = 0;
    for (int s = 1; s <= NSRC; s++)
      if (pm[s] && prio_m[s] > thr && prio_m[s] > bp) begin bp = prio_m[s]; id = s; end
    return id;
  endfunction

  task automatic drain(int thr, logic complete_now, inout logic [31:0] claimed);
    logic [31:0] got;
    for (int k = 0; k < 33; k++) begin
      int exp = best(pend_m, thr);
      rd(CLAIM0, got);
      check("R5 R4 claim order", got, 32'(exp));
      if (exp == 0) break;
      pend_m[exp] = 1'b0;
      claimed[exp] = 1'b1;
      if (complete_now) wr(CLAIM0, 32'(exp));
    end
  endtask

  task automatic run_pattern(logic [31:0] mask, int thr);
    logic [31:0] claimed = '0;
    wr(THR0, 32'(thr));
    @(negedge clk); src = mask[NSRC:1];
    pend_m = pend_m | (mask & 32'hFFFF_FFFE);
    idle(3);
    check("R10 irq ctx0", 32'(irq[0]), 32'(best(pend_m, thr) != 0));
    check("R10 irq ctx1", 32'(irq[1]), 32'd0);
    drain(thr, 1'b0, claimed);
    @(negedge clk); src = '0;
    for (int s = 1; s <= NSRC; s++) if (claimed[s]) wr(CLAIM0, 32'(s));
    if (thr != 0) begin
      wr(THR0, 32'd0);
      claimed = '0;
      drain(0, 1'b1, claimed);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog requirement=all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(5);
    rst = 1'b0;
    idle(1);
    // Reset state
    check("R11 reset rdata", rdata, 32'd0);
    check("R10 reset irq", 32'(irq), 32'd0);
    check("R9 reset pending", 32'(pending), 32'd0);
    rd(32'h14, v);  check("R1 reset prio", v, 32'd0);
    rd(THR0, v);    check("R3 reset thr", v, 32'd0);

    // R1: priority registers, upper bits discarded
    for (int s = 1; s <= NSRC; s++) begin
      prio_m[s] = (5 * s + 1) % 8;
      wr(32'(4 * s), 32'hFFFF_FFF8 | 32'(prio_m[s]));
    end
    for (int s = 1; s <= NSRC; s++) begin
      rd(32'(4 * s), v); check("R1 prio readback", v, 32'(prio_m[s]));
    end
    wr(32'h0, 32'd7); rd(32'h0, v); check("R1 id0 prio", v, 32'd0);

    // R2: enable masks
    wr(32'h2000, 32'hFFFF_FFFF); rd(32'h2000, v); check("R2 en ctx0", v, 32'hFFFF_FFFE);
    wr(32'h2080, 32'h0000_0F00); rd(32'h2080, v); check("R2 en ctx1", v, 32'h0000_0F00);
    rd(32'h2000, v); check("R2 en ctx0 independent", v, 32'hFFFF_FFFE);
    wr(32'h2080, 32'h0);

    // R3: thresholds
    wr(THR0, 32'd5); wr(THR1, 32'hFFFF_FFFA);
    rd(THR0, v); check("R3 thr ctx0", v, 32'd5);
    rd(THR1, v); check("R3 thr ctx1", v, 32'd2);

    // R4 R5 R10: arbitration sweeps
    run_pattern(32'hFFFF_FFFF, 0);
    run_pattern(32'h8421_0842, 0);
    run_pattern(32'h00F0_F0F0, 4);
    run_pattern(32'hFFFF_FFFF, 7);
    run_pattern(32'h1248_1248, 3);

    // R9: pending view (priority-0 sources stay pending)
    rd(32'h1000, v); check("R9 pending word", v, pend_m);
    check("R9 pending port", {pending, 1'b0}, pend_m);

    // R6 R7 R10: level source 6 (priority 7)
    @(negedge clk); src[6] = 1'b1;
    @(negedge clk);
    check("R7 level pends", 32'(pending[6]), 32'd1);
    check("R10 irq not yet", 32'(irq[0]), 32'd0);
    @(negedge clk);
    check("R10 irq one cycle later", 32'(irq[0]), 32'd1);
    rd(CLAIM0, v); check("R5 claim level", v, 32'd6);
    idle(1);
    check("R10 irq drops after claim", 32'(irq[0]), 32'd0);
    wr(CLAIM0, 32'd7);
    wr(CLAIM1, 32'd6);
    idle(3);
    check("R6 bad completion ignored", 32'(pending[6]), 32'd0);
    wr(CLAIM0, 32'd6);
    idle(2);
    check("R7 level resample", 32'(pending[6]), 32'd1);
    rd(CLAIM0, v); check("R6 reclaim", v, 32'd6);
    src[6] = 1'b0;
    wr(CLAIM0, 32'd6);
    idle(3);
    check("R7 low line no pend", 32'(pending[6]), 32'd0);

    // R8 R9: edge source 9 (priority 6)
    wr(32'h1100, 32'h0000_0200);
    rd(32'h1100, v); check("R9 mode readback", v, 32'h0000_0200);
    pulse(9); idle(1);
    check("R8 edge latched", 32'(pending[9]), 32'd1);
    pulse(9); idle(1);
    rd(CLAIM0, v); check("R8 claim edge", v, 32'd9);
    rd(CLAIM0, v); check("R8 second edge dropped", v, 32'd0);
    pulse(9); idle(2);
    check("R8 edge in flight dropped", 32'(pending[9]), 32'd0);
    wr(CLAIM0, 32'd9); idle(3);
    check("R8 no edge no pend", 32'(pending[9]), 32'd0);
    @(negedge clk); src[9] = 1'b1;
    idle(2);
    check("R8 held rise latched", 32'(pending[9]), 32'd1);
    rd(CLAIM0, v); check("R8 claim held", v, 32'd9);
    wr(CLAIM0, 32'd9); idle(3);
    check("R8 held high no rearm", 32'(pending[9]), 32'd0);
    src[9] = 1'b0; idle(1);
    pulse(9); idle(1);
    check("R8 new edge after completion", 32'(pending[9]), 32'd1);
    rd(CLAIM0, v); check("R8 final claim", v, 32'd9);
    wr(CLAIM0, 32'd9);

    // R11: unmapped reads
    rd(32'h3000, v);   check("R11 unmapped gap", v, 32'd0);
    rd(32'h20_2004, v); check("R11 context beyond range", v, 32'd0);
    rd(32'h1200, v);   check("R11 unmapped low", v, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule